// File: doc/BRIEF.md
# SD Host Wrapper Register Block

This block is the global register front end that sits ahead of one or two SD host slot controllers. It answers a 4 KB window on a simple 32-bit request bus. The lowest 256 bytes hold the shared registers:

- a slot-information word with a self-clearing reset request bit;
- a debounce setting;
- plain storage words for bus, write-protect polarity and card detect;
- an interrupt status word that mirrors the level of each slot's interrupt line.

Four words in that page are aliases. Each one reaches through to the capability or max-current word that lives inside a slot controller.

Accesses to the page at 0x100 go to slot 0. Accesses to the page at 0x200 go to slot 1. The block passes them out on a shared slot port with one select line per slot. The slot returns read data in the same cycle, and the block registers it. The slot interrupt levels are gathered into the status word and ORed into one interrupt output.

The request side has no back-pressure: the block accepts a request in every cycle that `req` is high. Read data comes back exactly one cycle later, marked by `rvalid`. Byte strobes are not supported. Address bits [1:0] are ignored, because only aligned 32-bit accesses are meaningful.

Top module: `sd_wrap_regs`

## Requirements
- R1: After reset the information word (0x000) reads 0x0001_0000 with one slot or 0x0003_0000 with two, the debounce word (0x004) reads 0x0000_0005, every other stored word reads zero, and `irq_out` is low.
- R2: A write to 0x000 stores all bits except bit 0, which always reads back as 0. A write with bit 0 set raises `rst_req_pulse` for exactly the following cycle.
- R3: Global offsets other than 0x000, the four aliases and 0xFC (for example 0x008, 0x0EC, 0x0F0) are independent 32-bit read/write words.
- R4: Offsets 0x010/0x018 reach slot 0 and 0x020/0x028 reach slot 1, at slot offsets 0x40 (capability) and 0x48 (max current). Reads return the slot's data and writes land in the slot.
- R5: An access at 0x100+k or 0x200+k asserts only `slot_sel[0]` or only `slot_sel[1]`, with `slot_addr` = k. At most one select is high at a time.
- R6: Bit n of the status word 0xFC equals the level of `slot_irq[n]` from the previous cycle. Writes to 0xFC have no effect.
- R7: `irq_out` is high exactly when any bit of the status word is set.
- R8: A read request yields `rvalid` high with data one cycle later. A write request or an idle cycle yields `rvalid` low.
- R9: Any access at 0x300 or above reads zero, changes nothing, and raises `err_pulse` for one cycle.
- R10: With a slot count of one, the slot 1 aliases and the 0x200 page read zero, assert no select, and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address in the 4 KB window |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | Access beyond the slot pages |
| slot_sel | output | NUM_SLOTS | Per-slot access select |
| slot_we | output | 1 | Write enable toward the slots |
| slot_addr | output | 8 | Byte offset inside the slot space |
| slot_wdata | output | 32 | Write data toward the slots |
| slot_rdata | input | 32*NUM_SLOTS | Same-cycle read data from each slot |
| slot_irq | input | NUM_SLOTS | Interrupt level from each slot |
| irq_out | output | 1 | Combined interrupt |
| rst_req_pulse | output | 1 | One-cycle reset request |

## Verification
Routing is tried with reads and writes to each alias, each slot page and each plain global word. Every slot word is preloaded with a value that encodes its slot and word index, so a wrong slot or a wrong offset shows up as a distinct value. Interrupt levels are raised and dropped one slot at a time and then overlapped. This separates a per-bit mirror from a shared flag, and shows that the combined output holds while either slot is still asserting. A second instance with one slot, whose slot data is a fixed nonzero pattern, shows that absent-slot accesses are blocked rather than merely unrouted.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int PAGE_W     = 8;
  localparam int GLOB_WORDS = 64;
  localparam int WIDX_W     = $clog2(GLOB_WORDS);
  localparam int MAX_SLOTS  = 2;

  localparam logic [WIDX_W-1:0] INFO_IDX = 6'd0;
  localparam logic [WIDX_W-1:0] DBNC_IDX = 6'd1;
  localparam logic [WIDX_W-1:0] STAT_IDX = 6'd63;

  localparam logic [PAGE_W-1:0] CAP_OFF  = 8'h40;
  localparam logic [PAGE_W-1:0] MAXC_OFF = 8'h48;

  localparam logic [DATA_W-1:0] DBNC_RST  = 32'h0000_0005;
  localparam logic [DATA_W-1:0] SLOT0_BIT = 32'h0001_0000;
  localparam logic [DATA_W-1:0] SLOT1_BIT = 32'h0002_0000;

  typedef enum logic [2:0] {
    K_NONE,
    K_GLOB,
    K_STAT,
    K_SLOT,
    K_ERR
  } acc_kind_e;

  function automatic logic is_alias(input logic [WIDX_W-1:0] w);
    return (w == 6'd4) || (w == 6'd6) || (w == 6'd8) || (w == 6'd10);
  endfunction
endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
  import sdw_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic              sidx,
  output logic [PAGE_W-1:0] soff,
  output logic [WIDX_W-1:0] widx
);
  logic [ADDR_W-PAGE_W-1:0] page;

  assign page = addr[ADDR_W-1:PAGE_W];
  assign widx = addr[PAGE_W-1:2];

  always_comb begin
    kind = K_NONE;
    sidx = 1'b0;
    soff = {addr[PAGE_W-1:2], 2'b00};
    if (page == '0) begin
      if (widx == STAT_IDX) begin
        kind = K_STAT;
      end else if (is_alias(widx)) begin
        sidx = widx[3];
        soff = widx[1] ? MAXC_OFF : CAP_OFF;
        kind = (int'(sidx) < NUM_SLOTS) ? K_SLOT : K_NONE;
      end else begin
        kind = K_GLOB;
      end
    end else if (page <= 4'd2) begin
      sidx = page[1];
      kind = (int'(sidx) < NUM_SLOTS) ? K_SLOT : K_NONE;
    end else begin
      kind = K_ERR;
    end
  end
endmodule

// File: rtl/sdw_glob_regs.sv
module sdw_glob_regs
  import sdw_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              rst_req
);
  localparam logic [DATA_W-1:0] INFO_RST =
    SLOT0_BIT | ((NUM_SLOTS == 2) ? SLOT1_BIT : '0);

  logic [GLOB_WORDS-1:0][DATA_W-1:0] words;

  for (genvar i = 0; i < GLOB_WORDS; i++) begin : g_word
    if (is_alias(WIDX_W'(i)) || (i == int'(STAT_IDX))) begin : g_hole
      assign words[i] = '0;
    end else begin : g_store
      localparam logic [DATA_W-1:0] RST_VAL =
        (i == int'(INFO_IDX)) ? INFO_RST :
        (i == int'(DBNC_IDX)) ? DBNC_RST : '0;
      localparam logic [DATA_W-1:0] WMASK =
        (i == int'(INFO_IDX)) ? ~32'h1 : '1;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= RST_VAL;
        end else if (wr_en && (widx == WIDX_W'(i))) begin
          q <= wdata & WMASK;
        end
      end
      assign words[i] = q;
    end
  end

  assign rd_word = words[widx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= wr_en && (widx == INFO_IDX) && wdata[0];
    end
  end
endmodule

// File: rtl/sdw_irq_collect.sv
module sdw_irq_collect #(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_irq,
  output logic [NUM_SLOTS-1:0] stat,
  output logic                 irq_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
    end else begin
      stat <= slot_irq;
    end
  end

  assign irq_out = |stat;
endmodule

// File: rtl/sd_wrap_regs.sv
module sd_wrap_regs
  import sdw_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic                        rvalid,
  output logic [DATA_W-1:0]           rdata,
  output logic                        err_pulse,
  output logic [NUM_SLOTS-1:0]        slot_sel,
  output logic                        slot_we,
  output logic [PAGE_W-1:0]           slot_addr,
  output logic [DATA_W-1:0]           slot_wdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] slot_rdata,
  input  logic [NUM_SLOTS-1:0]        slot_irq,
  output logic                        irq_out,
  output logic                        rst_req_pulse
);
  acc_kind_e         kind;
  logic              sidx;
  logic [PAGE_W-1:0] soff;
  logic [WIDX_W-1:0] widx;
  logic [DATA_W-1:0] glob_rd;
  logic [NUM_SLOTS-1:0] stat;
  logic [DATA_W-1:0] slot_rd [MAX_SLOTS];
  logic [DATA_W-1:0] rd_next;
  logic              is_read;

  sdw_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .addr(addr), .kind(kind), .sidx(sidx), .soff(soff), .widx(widx)
  );

  sdw_glob_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req && we && (kind == K_GLOB)),
    .widx(widx), .wdata(wdata),
    .rd_word(glob_rd), .rst_req(rst_req_pulse)
  );

  sdw_irq_collect #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq),
    .stat(stat), .irq_out(irq_out)
  );

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    if (s < NUM_SLOTS) begin : g_on
      assign slot_sel[s] = req && (kind == K_SLOT) && (int'(sidx) == s);
      assign slot_rd[s]  = slot_rdata[s*DATA_W +: DATA_W];
    end else begin : g_off
      assign slot_rd[s] = '0;
    end
  end

  assign slot_we    = req && we && (kind == K_SLOT);
  assign slot_addr  = soff;
  assign slot_wdata = wdata;
  assign is_read    = req && !we;

  always_comb begin
    unique case (kind)
      K_GLOB:  rd_next = glob_rd;
      K_STAT:  rd_next = DATA_W'(stat);
      K_SLOT:  rd_next = slot_rd[sidx];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid    <= 1'b0;
      rdata     <= '0;
      err_pulse <= 1'b0;
    end else begin
      rvalid    <= is_read;
      err_pulse <= req && (kind == K_ERR);
      if (is_read) begin
        rdata <= rd_next;
      end
    end
  end
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker #(
  parameter int NUM_SLOTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req,
  input logic                 we,
  input logic                 rvalid,
  input logic                 err_pulse,
  input logic [NUM_SLOTS-1:0] slot_sel,
  input logic [NUM_SLOTS-1:0] slot_irq,
  input logic                 irq_out,
  input logic                 rst_req_pulse
);
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);  // R8
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);  // R8
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));  // R5
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == (|$past(slot_irq))));  // R7
  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req));  // R9
  AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_pulse |-> $past(req && we));  // R2
endmodule

bind sd_wrap_regs sdw_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .rvalid(rvalid),
  .err_pulse(err_pulse), .slot_sel(slot_sel), .slot_irq(slot_irq),
  .irq_out(irq_out), .rst_req_pulse(rst_req_pulse)
);

// File: tb/sd_wrap_regs_tb_top.sv
`timescale 1ns/1ps
module sd_wrap_regs_tb_top;
  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h010, 32'hA000_0010, 4'd4},  // R4 slot0 capability
    '{1'b0, 12'h018, 32'hA000_0012, 4'd4},  // R4 slot0 max current
    '{1'b0, 12'h020, 32'hA001_0010, 4'd4},  // R4 slot1 capability
    '{1'b0, 12'h028, 32'hA001_0012, 4'd4},  // R4 slot1 max current
    '{1'b1, 12'h010, 32'h0000_1234, 4'd4},
    '{1'b0, 12'h010, 32'h0000_1234, 4'd4},
    '{1'b0, 12'h104, 32'hA000_0001, 4'd5},  // R5 slot0 page
    '{1'b0, 12'h208, 32'hA001_0002, 4'd5},  // R5 slot1 page
    '{1'b1, 12'h2FC, 32'h0000_BEEF, 4'd5},
    '{1'b0, 12'h2FC, 32'h0000_BEEF, 4'd5},
    '{1'b0, 12'h140, 32'h0000_1234, 4'd5},
    '{1'b1, 12'h008, 32'hCAFE_F00D, 4'd3},  // R3 plain words
    '{1'b0, 12'h008, 32'hCAFE_F00D, 4'd3},
    '{1'b1, 12'h0EC, 32'h0000_0001, 4'd3},
    '{1'b0, 12'h0EC, 32'h0000_0001, 4'd3},
    '{1'b1, 12'h0F0, 32'hFFFF_FFFF, 4'd3},
    '{1'b0, 12'h0F0, 32'hFFFF_FFFF, 4'd3},
    '{1'b0, 12'h0EC, 32'h0000_0001, 4'd3},
    '{1'b1, 12'h0FC, 32'h0000_0003, 4'd6},  // R6 status not writable
    '{1'b0, 12'h0FC, 32'h0000_0000, 4'd6},
    '{1'b1, 12'h000, 32'h0003_0101, 4'd2},  // R2 bit 0 not stored
    '{1'b0, 12'h000, 32'h0003_0100, 4'd2},
    '{1'b1, 12'h400, 32'h1111_1111, 4'd9},  // R9 beyond slot pages
    '{1'b0, 12'h400, 32'h0000_0000, 4'd9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid, err_pulse, slot_we, irq_out, rst_req_pulse;
  logic [31:0] rdata, slot_wdata;
  logic [1:0] slot_sel;
  logic [7:0] slot_addr;
  logic [63:0] slot_rdata;
  logic [1:0] slot_irq = 2'b00;

  logic rvalid1, err1, slot_we1, irq1, rst1;
  logic [31:0] rdata1, slot_wdata1;
  logic [0:0] slot_sel1;
  logic [7:0] slot_addr1;

  logic [31:0] mem0 [64];
  logic [31:0] mem1 [64];

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  sd_wrap_regs #(.NUM_SLOTS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rvalid(rvalid), .rdata(rdata), .err_pulse(err_pulse),
    .slot_sel(slot_sel), .slot_we(slot_we), .slot_addr(slot_addr),
    .slot_wdata(slot_wdata), .slot_rdata(slot_rdata), .slot_irq(slot_irq),
    .irq_out(irq_out), .rst_req_pulse(rst_req_pulse)
  );

  sd_wrap_regs #(.NUM_SLOTS(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rvalid(rvalid1), .rdata(rdata1), .err_pulse(err1),
    .slot_sel(slot_sel1), .slot_we(slot_we1), .slot_addr(slot_addr1),
    .slot_wdata(slot_wdata1), .slot_rdata(32'hDEAD_BEEF), .slot_irq(1'b0),
    .irq_out(irq1), .rst_req_pulse(rst1)
  );

  assign slot_rdata = {mem1[slot_addr[7:2]], mem0[slot_addr[7:2]]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 64; w++) begin
        mem0[w] <= 32'hA000_0000 | 32'(w);
        mem1[w] <= 32'hA001_0000 | 32'(w);
      end
    end else if (slot_we) begin
      if (slot_sel[0]) mem0[slot_addr[7:2]] <= slot_wdata;
      if (slot_sel[1]) mem1[slot_addr[7:2]] <= slot_wdata;
    end
  end

  task automatic check(input logic ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  logic [31:0] r_d, r_d1;
  logic r_v, r_e, r_e1;
  logic [1:0] r_sel;
  logic [0:0] r_sel1;
  logic [7:0] r_sa;

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    r_sel = slot_sel; r_sel1 = slot_sel1; r_sa = slot_addr;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r_d = rdata; r_v = rvalid; r_e = err_pulse;
    r_d1 = rdata1; r_e1 = err1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    check(irq_out == 1'b0, "R1", 32'(irq_out), 32'h0);
    bus(1'b0, 12'h000, '0);
    check(r_d == 32'h0003_0000, "R1", r_d, 32'h0003_0000);
    check(r_d1 == 32'h0001_0000, "R1", r_d1, 32'h0001_0000);
    bus(1'b0, 12'h004, '0);
    check(r_d == 32'h0000_0005, "R1", r_d, 32'h5);
    bus(1'b0, 12'h0F0, '0);
    check(r_d == 32'h0, "R1", r_d, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].we, VEC[i].addr, VEC[i].data);
      check(r_v == !VEC[i].we, "R8", 32'(r_v), 32'(!VEC[i].we));
      if (!VEC[i].we)
        check(r_d == VEC[i].data, $sformatf("R%0d", VEC[i].rq), r_d, VEC[i].data);
      if (VEC[i].addr >= 12'h300)
        check(r_e == 1'b1, "R9", 32'(r_e), 32'h1);
    end

    // R4 / R5 slot port fields
    bus(1'b0, 12'h028, '0);
    check(r_sel == 2'b10 && r_sa == 8'h48, "R4", {r_sel, r_sa}, {2'b10, 8'h48});
    bus(1'b0, 12'h1A4, '0);
    check(r_sel == 2'b01 && r_sa == 8'hA4, "R5", {r_sel, r_sa}, {2'b01, 8'hA4});
    bus(1'b0, 12'h0EC, '0);
    check(r_sel == 2'b00, "R5", 32'(r_sel), 32'h0);

    // R2 reset request pulse
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h000; wdata = 32'h0000_0001;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check(rst_req_pulse == 1'b1, "R2", 32'(rst_req_pulse), 32'h1);
    @(negedge clk);
    check(rst_req_pulse == 1'b0, "R2", 32'(rst_req_pulse), 32'h0);
    bus(1'b0, 12'h000, '0);
    check(r_d == 32'h0, "R2", r_d, 32'h0);

    // R6 / R7 interrupt mirror
    @(negedge clk); slot_irq = 2'b01;
    @(negedge clk);
    check(irq_out == 1'b1, "R7", 32'(irq_out), 32'h1);
    bus(1'b0, 12'h0FC, '0);
    check(r_d == 32'h1, "R6", r_d, 32'h1);
    slot_irq = 2'b11;
    bus(1'b0, 12'h0FC, '0);
    check(r_d == 32'h3, "R6", r_d, 32'h3);
    slot_irq = 2'b10;
    bus(1'b0, 12'h0FC, '0);
    check(r_d == 32'h2, "R6", r_d, 32'h2);
    check(irq_out == 1'b1, "R7", 32'(irq_out), 32'h1);
    slot_irq = 2'b00;
    @(negedge clk);
    check(irq_out == 1'b0, "R7", 32'(irq_out), 32'h0);
    bus(1'b0, 12'h0FC, '0);
    check(r_d == 32'h0, "R6", r_d, 32'h0);

    // R10 single-slot instance
    bus(1'b0, 12'h020, '0);
    check(r_d1 == 32'h0 && r_sel1 == 1'b0, "R10", r_d1, 32'h0);
    bus(1'b0, 12'h200, '0);
    check(r_d1 == 32'h0 && r_e1 == 1'b0, "R10", r_d1, 32'h0);
    bus(1'b1, 12'h028, 32'h5555_5555);
    check(r_sel1 == 1'b0, "R10", 32'(r_sel1), 32'h0);
    bus(1'b0, 12'h100, '0);
    check(r_d1 == 32'hDEAD_BEEF, "R10", r_d1, 32'hDEAD_BEEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule